// File: doc/BRIEF.md
# Paged CPU Access Port for a Time-Slot Switch

This block sits between a small microprocessor bus and the storage of a time-slot switch. The CPU sees only 64 byte addresses. The lower half of that space holds one byte: the control register. The upper half is a 32-byte window. Each byte in the window is one channel of one stream. The control register chooses which stream the window covers and which memory it reaches. That memory is one of three: the data memory (the CPU can only read it), the low connection memory, or the high connection memory.

The control register also has a split flag. When the split flag is set, reads through the window always return data-memory bytes, while writes still go to the connection memory named by the select field. This lets the CPU read incoming traffic and program connections without rewriting the register between the two. Bit 6 of the register, the processor-mode flag, is passed out to the switching core. The memories themselves sit outside the block. The block drives their shared address, their write data and one write enable for each connection memory. It samples the three read buses in the cycle of the request.

An access is a one-cycle request strobe with a read/write flag. Read data appears one clock after the request and holds until the next read.

Top module: `cpu_window_port`

## Requirements
- R1: After reset the control register is 0x00, `rdData` is 0x00 and `procMode` is 0.
- R2: A write with `addr[5]`=0 loads the control register from `wrData`, whatever the value of `addr[4:0]`, and raises no memory write enable.
- R3: A read with `addr[5]`=0 returns the control register. Bit 5 always reads as 0.
- R4: `memAddr` equals {control bits 2:0 (stream), `addr[4:0]` (channel)}. The stream part changes only after a control-register write.
- R5: A window write (`addr[5]`=1) with select field bits 4:3 = 2'b10 pulses `cmLowWe`, and with 2'b11 pulses `cmHighWe`. The pulse is in the request cycle, with `memWrData` = `wrData`. This holds whether the split flag (bit 7) is set or not.
- R6: A window write with select code 2'b01 (data memory) or the reserved 2'b00 raises neither write enable. The two enables are never high together, and never high without a write request.
- R7: With bit 7 = 0, a window read returns `dmRdData` for select 2'b01, `cmLowRdData` for 2'b10, `cmHighRdData` for 2'b11, and 0x00 for 2'b00.
- R8: With bit 7 = 1, every window read returns `dmRdData`, whatever the select code.
- R9: `rdData` takes the read result on the clock edge that ends the read request cycle. It keeps that value through writes and idle cycles.
- R10: `procMode` always equals bit 6 of the control register. It updates on the edge that ends a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Bit 5 picks window (1) or control register (0); bits 4:0 pick the channel |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | Registered read result |
| memAddr | output | 8 | {stream, channel} address to the three memories |
| memWrData | output | 8 | Write data to the connection memories |
| cmLowWe | output | 1 | Low connection memory write enable |
| cmHighWe | output | 1 | High connection memory write enable |
| dmRdData | input | 8 | Data memory byte at `memAddr` |
| cmLowRdData | input | 8 | Low connection memory byte at `memAddr` |
| cmHighRdData | input | 8 | High connection memory byte at `memAddr` |
| procMode | output | 1 | Processor-mode flag to the switching core |

## Verification
The bench writes the control register with bit 5 set and with non-zero low address bits. A design that fails to mask bit 5 reads it back wrong, and one that decodes more address bits misses the load. It writes under the data-memory and reserved select codes. It also turns on split mode with each connection select. A design that steers split writes to the data memory, or that lets split reads follow the select field, returns connection bytes where data-memory bytes are expected. It fills one stream's low and high pages and then reads a different stream. A design that drops the stream bits from the address aliases the pages and returns the wrong bytes. Idle cycles between reads show whether a design lets `rdData` drift or clears it when no read is made.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  // control register field positions (fixed by the register layout)
  localparam int SPLIT_BIT = 7;
  localparam int PMODE_BIT = 6;
  localparam int SPARE_BIT = 5;
  localparam int MSEL_LO   = 3;
  localparam int STREAM_LO = 0;

  typedef enum logic [1:0] {
    MSEL_NONE  = 2'b00,
    MSEL_DATA  = 2'b01,
    MSEL_CLOW  = 2'b10,
    MSEL_CHIGH = 2'b11
  } msel_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTRL,
    RD_DATA,
    RD_CLOW,
    RD_CHIGH
  } rdsrc_e;

  typedef struct packed {
    logic   ctrlLoad;
    logic   rdLoad;
    rdsrc_e rdSrc;
    logic   lowWe;
    logic   highWe;
  } strobe_t;
endpackage

// File: rtl/cwp_ctrl.sv
module cwp_ctrl
  import cwp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output strobe_t             strobe,
  output logic [DATA_W-1:0]   ctrlQ,
  output logic [STREAM_W-1:0] stream,
  output logic                procMode
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << SPARE_BIT);

  logic  isWindow;
  logic  splitOn;
  msel_e memSel;

  assign isWindow = addr[ADDR_W-1];
  assign splitOn  = ctrlQ[SPLIT_BIT];
  assign memSel   = msel_e'(ctrlQ[MSEL_LO+:2]);
  assign stream   = ctrlQ[STREAM_LO+:STREAM_W];
  assign procMode = ctrlQ[PMODE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.ctrlLoad) begin
      ctrlQ <= wrData & KEEP_MASK;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.rdSrc = RD_ZERO;
    if (req) begin
      if (!isWindow) begin
        if (wr) begin
          strobe.ctrlLoad = 1'b1;
        end else begin
          strobe.rdLoad = 1'b1;
          strobe.rdSrc  = RD_CTRL;
        end
      end else if (wr) begin
        unique case (memSel)
          MSEL_CLOW:  strobe.lowWe  = 1'b1;
          MSEL_CHIGH: strobe.highWe = 1'b1;
          default:    ;
        endcase
      end else begin
        strobe.rdLoad = 1'b1;
        if (splitOn) begin
          strobe.rdSrc = RD_DATA;
        end else begin
          unique case (memSel)
            MSEL_DATA:  strobe.rdSrc = RD_DATA;
            MSEL_CLOW:  strobe.rdSrc = RD_CLOW;
            MSEL_CHIGH: strobe.rdSrc = RD_CHIGH;
            default:    strobe.rdSrc = RD_ZERO;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cwp_datapath.sv
module cwp_datapath
  import cwp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic [STREAM_W-1:0]        stream,
  input  logic [CHAN_W-1:0]          chan,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [DATA_W-1:0]          ctrlQ,
  input  logic [DATA_W-1:0]          dmRd,
  input  logic [DATA_W-1:0]          lowRd,
  input  logic [DATA_W-1:0]          highRd,
  output logic [DATA_W-1:0]          rdData,
  output logic [STREAM_W+CHAN_W-1:0] memAddr,
  output logic [DATA_W-1:0]          memWrData,
  output logic                       lowWe,
  output logic                       highWe
);
  logic [DATA_W-1:0] rdNext;

  generate
    if (STREAM_W > 0) begin : g_paged
      assign memAddr = {stream, chan};
    end else begin : g_flat
      assign memAddr = chan;
    end
  endgenerate

  assign memWrData = wrData;
  assign lowWe     = strobe.lowWe;
  assign highWe    = strobe.highWe;

  always_comb begin
    unique case (strobe.rdSrc)
      RD_CTRL:  rdNext = ctrlQ;
      RD_DATA:  rdNext = dmRd;
      RD_CLOW:  rdNext = lowRd;
      RD_CHIGH: rdNext = highRd;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      rdData <= rdNext;
    end
  end
endmodule

// File: rtl/cpu_window_port.sv
module cpu_window_port
  import cwp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int STREAM_W = $clog2(STREAMS),
  localparam int CHAN_W   = $clog2(CHANNELS),
  localparam int ADDR_W   = CHAN_W + 1,
  localparam int MADDR_W  = STREAM_W + CHAN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               req,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [MADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               cmLowWe,
  output logic               cmHighWe,
  input  logic [DATA_W-1:0]  dmRdData,
  input  logic [DATA_W-1:0]  cmLowRdData,
  input  logic [DATA_W-1:0]  cmHighRdData,
  output logic               procMode
);
  strobe_t             strobe;
  logic [DATA_W-1:0]   ctrlQ;
  logic [STREAM_W-1:0] stream;

  cwp_ctrl #(.DATA_W(DATA_W), .STREAM_W(STREAM_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wrData(wrData),
    .strobe(strobe), .ctrlQ(ctrlQ), .stream(stream), .procMode(procMode)
  );

  cwp_datapath #(.DATA_W(DATA_W), .STREAM_W(STREAM_W), .CHAN_W(CHAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stream(stream),
    .chan(addr[CHAN_W-1:0]), .wrData(wrData), .ctrlQ(ctrlQ),
    .dmRd(dmRdData), .lowRd(cmLowRdData), .highRd(cmHighRdData),
    .rdData(rdData), .memAddr(memAddr), .memWrData(memWrData),
    .lowWe(cmLowWe), .highWe(cmHighWe)
  );
endmodule

// File: rtl/cpu_window_port_chk.sv
module cpu_window_port_chk #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int MADDR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               req,
  input logic               wr,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [MADDR_W-1:0] memAddr,
  input logic               cmLowWe,
  input logic               cmHighWe,
  input logic               procMode
);
  localparam int CH_W = ADDR_W - 1;

  assert_we_needs_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmLowWe || cmHighWe) |-> (req && wr && addr[ADDR_W-1]));

  assert_we_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(cmLowWe && cmHighWe));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(req && !wr) |=> $stable(rdData));

  assert_spare_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (req && !wr && !addr[ADDR_W-1]) |=> (rdData[5] == 1'b0));

  assert_pmode_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (req && wr && !addr[ADDR_W-1]) |=> (procMode == $past(wrData[6])));

  assert_stream_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(req && wr && !addr[ADDR_W-1]) |-> $stable(memAddr[MADDR_W-1:CH_W]));
endmodule

bind cpu_window_port cpu_window_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MADDR_W(MADDR_W)
) u_chk (.*);

// File: tb/cpu_window_port_bench.sv
`timescale 1ns/1ps
module cpu_window_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       req = 1'b0;
  logic       wr = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData, memAddr, memWrData, dmRdData, cmLowRdData, cmHighRdData;
  logic       cmLowWe, cmHighWe, procMode;

  logic [7:0] dmArr   [256];
  logic [7:0] lowMem  [256];
  logic [7:0] highMem [256];
  logic [7:0] expLow  [256];
  logic [7:0] expHigh [256];
  logic [7:0] mCtrl = 8'h00;
  logic [7:0] expRd = 8'h00;
  int nChecks = 0;
  int nFail   = 0;
  bit running = 1'b0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cpu_window_port u_cpu_window_port (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wrData(wrData),
    .rdData(rdData), .memAddr(memAddr), .memWrData(memWrData),
    .cmLowWe(cmLowWe), .cmHighWe(cmHighWe), .dmRdData(dmRdData),
    .cmLowRdData(cmLowRdData), .cmHighRdData(cmHighRdData), .procMode(procMode)
  );

  // bench-side memories driven by the port
  assign dmRdData     = dmArr[memAddr];
  assign cmLowRdData  = lowMem[memAddr];
  assign cmHighRdData = highMem[memAddr];

  always @(posedge clk) begin
    if (cmLowWe)  lowMem[memAddr]  <= memWrData;
    if (cmHighWe) highMem[memAddr] <= memWrData;
  end

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  // expected read result from the model
  function automatic logic [7:0] modelRead(input logic [5:0] a);
    logic [7:0] idx;
    idx = {mCtrl[2:0], a[4:0]};
    if (!a[5]) return mCtrl;
    if (mCtrl[7]) return dmArr[idx];
    case (mCtrl[4:3])
      2'b01:   return dmArr[idx];
      2'b10:   return expLow[idx];
      2'b11:   return expHigh[idx];
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison against the model (R9 hold, R10 flag, R6 idle enables)
  always @(negedge clk) begin
    if (running) begin
      chk("R9 rdData vs model", rdData, expRd);
      chk("R10 procMode", {7'd0, procMode}, {7'd0, mCtrl[6]});
      if (!req) chk("R6 idle write enables", {6'd0, cmLowWe, cmHighWe}, 8'h00);
    end
  end

  task automatic access(input logic w, input logic [5:0] a, input logic [7:0] d);
    logic expLowWe, expHighWe;
    logic [7:0] rv;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wrData = d;
    #1;
    expLowWe  = w && a[5] && (mCtrl[4:3] == 2'b10);
    expHighWe = w && a[5] && (mCtrl[4:3] == 2'b11);
    chk(w ? "R5 R6 write enables" : "R6 no enable on read",
        {6'd0, cmLowWe, cmHighWe}, {6'd0, expLowWe, expHighWe});
    if (a[5]) chk("R4 memAddr", memAddr, {mCtrl[2:0], a[4:0]});
    if (expLowWe || expHighWe) chk("R5 memWrData", memWrData, d);
    rv = modelRead(a);
    if (w) begin
      if (!a[5]) mCtrl = d & 8'hDF;
      else if (expLowWe)  expLow[{mCtrl[2:0], a[4:0]}]  = d;
      else if (expHighWe) expHigh[{mCtrl[2:0], a[4:0]}] = d;
    end
    @(posedge clk);
    #1;
    req = 1'b0; wr = 1'b0;
    if (!w) begin
      expRd = rv;
      chk(a[5] ? "R7 R8 window read" : "R3 control read", rdData, rv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmArr[i]   = 8'((i * 37 + 11) ^ (i >> 3));
      lowMem[i]  = 8'h00;
      highMem[i] = 8'h00;
      expLow[i]  = 8'h00;
      expHigh[i] = 8'h00;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdData after reset", rdData, 8'h00);
    chk("R1 procMode after reset", {7'd0, procMode}, 8'h00);
    running = 1'b1;
    access(1'b0, 6'h1F, 8'h00);                 // R1 control reads 0x00
    access(1'b1, 6'h15, 8'h33);                 // R2 load, low bits ignored, bit5 set
    access(1'b0, 6'h0A, 8'h00);                 // R3 reads 0x13
    // low connection memory, stream 3
    for (int c = 0; c < 32; c++) access(1'b1, 6'(32 + c), 8'(c * 5 + 1));
    for (int c = 0; c < 32; c += 3) access(1'b0, 6'(32 + c), 8'h00);  // R7 low
    // high connection memory, stream 3
    access(1'b1, 6'h00, 8'h1B);                 // select 11
    for (int c = 0; c < 32; c += 2) access(1'b1, 6'(32 + c), 8'(8'hA0 + c));
    for (int c = 0; c < 32; c += 4) access(1'b0, 6'(32 + c), 8'h00);  // R7 high
    // other stream sees untouched bytes (R4)
    access(1'b1, 6'h00, 8'h15);                 // low, stream 5
    access(1'b0, 6'h27, 8'h00);
    access(1'b1, 6'h27, 8'h66);
    idle(3);                                    // R9 hold across idle
    access(1'b0, 6'h27, 8'h00);
    // data memory select: writes ignored (R6), reads from data memory (R7)
    access(1'b1, 6'h00, 8'h0C);
    access(1'b1, 6'h21, 8'hEE);
    access(1'b0, 6'h21, 8'h00);
    // reserved select: writes ignored (R6), reads zero (R7)
    access(1'b1, 6'h00, 8'h04);
    access(1'b1, 6'h22, 8'h77);
    access(1'b0, 6'h22, 8'h00);
    // split, select low, stream 2 (R8)
    access(1'b1, 6'h00, 8'h92);
    access(1'b1, 6'h30, 8'h5A);
    access(1'b0, 6'h30, 8'h00);
    access(1'b1, 6'h00, 8'h12);
    access(1'b0, 6'h30, 8'h00);
    // split, select high, stream 2
    access(1'b1, 6'h00, 8'h9A);
    access(1'b1, 6'h31, 8'hC3);
    access(1'b0, 6'h31, 8'h00);
    access(1'b1, 6'h00, 8'h1A);
    access(1'b0, 6'h31, 8'h00);
    // split with reserved select still reads data memory (R8)
    access(1'b1, 6'h00, 8'h84);
    access(1'b0, 6'h3F, 8'h00);
    // processor mode flag (R10)
    access(1'b1, 6'h00, 8'h7F);
    access(1'b0, 6'h00, 8'h00);
    idle(2);
    access(1'b1, 6'h1F, 8'h00);
    access(1'b0, 6'h00, 8'h00);
    idle(4);
    running = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule